// File: doc/BRIEF.md
# Register-Immediate Integer ALU

This block is the combinational integer execution unit of a small load/store processor core. Each cycle it receives an operation selector, an operand-form selector, a first register operand, a second register operand and a 16-bit constant. It returns a 32-bit result and two error flags. The form selector decides what the second operand is: the register value, the constant sign-extended, or the constant zero-extended. The same operation then runs on that second operand.

The operations are add, subtract, multiply, signed divide, signed remainder, three-way compare, OR, XOR, AND, bit-clear, logical shift, arithmetic shift and a bound check. Both shifts take a signed count: a positive count shifts left and a negative count shifts right. A zero divisor does not give an undefined value. It gives a result of zero and raises a divide-error flag. The bound check raises its own flag when an index falls outside a range.

Top module: `regimm_alu`

## Requirements
- R1: ADD (op 0) returns A+B and SUB (op 1) returns A-B, both wrapping modulo 2^32.
- R2: The form selector picks the second operand B. Form 0 uses the second register. Form 1 uses the 16-bit constant sign-extended. Form 2 uses the constant zero-extended. Form 3 behaves as form 0.
- R3: MUL (op 2) returns the low 32 bits of the product A*B.
- R4: DIV (op 3) and MOD (op 4) treat A and B as signed and round toward zero. The remainder takes the sign of A. The case -2^31 / -1 gives the quotient 0x80000000 and the remainder 0.
- R5: DIV or MOD with B equal to 0 returns result 0 and drives div_err_o high. For every other operation, and for a non-zero B, div_err_o is low.
- R6: CMP (op 5) returns 0xFFFFFFFF if A<B, 0 if A==B and 1 if A>B, with a signed comparison.
- R7: OR (op 6), XOR (op 7) and AND (op 8) return the bitwise combination of A and B.
- R8: BIC (op 9) returns A AND (NOT B).
- R9: LSH (op 10) reads B as a signed count. A count of 0 to 31 shifts A left and fills with zeros. A count of -1 to -31 shifts A right by the magnitude and fills with zeros. A count with magnitude 32 or more returns 0.
- R10: ASH (op 11) shifts left like LSH. For a negative count it shifts right and replicates bit 31. A right shift of magnitude 32 or more returns 32 copies of bit 31.
- R11: CHK (op 12) returns A unchanged. It drives bound_err_o high when signed A is negative or signed A >= signed B.
- R12: bound_err_o is low for every operation other than CHK. Ops 13 to 15 are reserved: they return 0 with both flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation selector (encodings in R1 to R12) |
| form_i | input | 2 | Second-operand form selector (R2) |
| opa_i | input | 32 | First register operand A |
| opb_i | input | 32 | Second register operand |
| imm_i | input | 16 | Instruction constant |
| result_o | output | 32 | Operation result |
| bound_err_o | output | 1 | Bound-check failure |
| div_err_o | output | 1 | Zero-divisor indication |

## Verification
The assertions placed in the top module re-evaluate a set of invariants whenever the inputs change:
- a zero divisor forces a zero result and sets the divide flag, and only then;
- a compare result is always one of its three codes;
- bit-clear never leaves a bit set that B also has set;
- a bound check with negative A always reports an error and passes A through;
- the flags stay quiet outside their own operations;
- a logical shift by 32 or more to the left clears the word.

The exact arithmetic values need the bench's reference functions and its chosen stimulus to show them:
- signed quotient and remainder rounding;
- the -2^31 / -1 case;
- sign-fill versus zero-fill right shifts;
- the extension of the constant in each form.

// File: rtl/regimm_alu_pkg.sv
package regimm_alu_pkg;

    localparam int XLEN  = 32;
    localparam int IMM_W = 16;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_MUL = 4'd2,
        OP_DIV = 4'd3,
        OP_MOD = 4'd4,
        OP_CMP = 4'd5,
        OP_OR  = 4'd6,
        OP_XOR = 4'd7,
        OP_AND = 4'd8,
        OP_BIC = 4'd9,
        OP_LSH = 4'd10,
        OP_ASH = 4'd11,
        OP_CHK = 4'd12,
        OP_R13 = 4'd13,
        OP_R14 = 4'd14,
        OP_R15 = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        FORM_REG  = 2'd0,
        FORM_SIMM = 2'd1,
        FORM_UIMM = 2'd2,
        FORM_ALT  = 2'd3
    } alu_form_e;

    typedef struct packed {
        logic bound_err;
        logic div_err;
    } alu_flags_t;

    function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] v);
        return {{(XLEN-IMM_W){v[IMM_W-1]}}, v};
    endfunction

    function automatic logic [XLEN-1:0] zext_imm(input logic [IMM_W-1:0] v);
        return {{(XLEN-IMM_W){1'b0}}, v};
    endfunction

    function automatic logic [XLEN-1:0] magnitude(input logic [XLEN-1:0] v);
        return v[XLEN-1] ? (~v + 1'b1) : v;
    endfunction

endpackage

// File: rtl/alu_opnd_ext.sv
module alu_opnd_ext
    import regimm_alu_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int IW = IMM_W
) (
    input  alu_form_e      form,
    input  logic [W-1:0]   reg_b,
    input  logic [IW-1:0]  imm,
    output logic [W-1:0]   eff_b
);
    always_comb begin
        unique case (form)
            FORM_SIMM: eff_b = {{(W-IW){imm[IW-1]}}, imm};
            FORM_UIMM: eff_b = {{(W-IW){1'b0}}, imm};
            default:   eff_b = reg_b;
        endcase
    end
endmodule

// File: rtl/alu_arith_unit.sv
module alu_arith_unit
    import regimm_alu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   res,
    output logic           bound_err
);
    logic signed [W-1:0] sa, sb;
    logic                lt_s, eq;
    logic [W-1:0]        cmp_code;

    assign sa   = $signed(a);
    assign sb   = $signed(b);
    assign lt_s = sa < sb;
    assign eq   = (a == b);

    always_comb begin
        if (eq)        cmp_code = '0;
        else if (lt_s) cmp_code = '1;
        else           cmp_code = {{(W-1){1'b0}}, 1'b1};
    end

    always_comb begin
        res       = '0;
        bound_err = 1'b0;
        unique case (op)
            OP_ADD: res = a + b;
            OP_SUB: res = a - b;
            OP_MUL: res = a * b;
            OP_CMP: res = cmp_code;
            OP_OR:  res = a | b;
            OP_XOR: res = a ^ b;
            OP_AND: res = a & b;
            OP_BIC: res = a & ~b;
            OP_CHK: begin
                res       = a;
                bound_err = a[W-1] | ~lt_s;
            end
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/alu_div_unit.sv
module alu_div_unit
    import regimm_alu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] quot,
    output logic [W-1:0] rem,
    output logic         zero_div
);
    logic [W-1:0] ua, ub, uq, ur;
    logic         neg_q, neg_r;

    assign ua       = magnitude(a);
    assign ub       = magnitude(b);
    assign zero_div = (b == '0);
    assign neg_q    = a[W-1] ^ b[W-1];
    assign neg_r    = a[W-1];

    always_comb begin
        if (zero_div) begin
            uq = '0;
            ur = '0;
        end else begin
            uq = ua / ub;
            ur = ua % ub;
        end
    end

    assign quot = neg_q ? (~uq + 1'b1) : uq;
    assign rem  = neg_r ? (~ur + 1'b1) : ur;
endmodule

// File: rtl/alu_shift_unit.sv
module alu_shift_unit
    import regimm_alu_pkg::*;
#(
    parameter int W     = XLEN,
    parameter bit ARITH = 1'b0
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] cnt,
    output logic [W-1:0] res
);
    localparam int SHW = $clog2(W);

    logic [W-1:0]   mag;
    logic           right, far;
    logic [SHW-1:0] amt;
    logic [W-1:0]   left_v, right_v, far_v;

    assign right  = cnt[W-1];
    assign mag    = magnitude(cnt);
    assign far    = |mag[W-1:SHW];
    assign amt    = mag[SHW-1:0];
    assign left_v = a << amt;

    generate
        if (ARITH) begin : g_arith
            assign right_v = $unsigned($signed(a) >>> amt);
            assign far_v   = right ? {W{a[W-1]}} : '0;
        end else begin : g_logic
            assign right_v = a >> amt;
            assign far_v   = '0;
        end
    endgenerate

    always_comb begin
        if (far)        res = far_v;
        else if (right) res = right_v;
        else            res = left_v;
    end
endmodule

// File: rtl/regimm_alu.sv
module regimm_alu
    import regimm_alu_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int IW = IMM_W
) (
    input  logic [3:0]    op_i,
    input  logic [1:0]    form_i,
    input  logic [W-1:0]  opa_i,
    input  logic [W-1:0]  opb_i,
    input  logic [IW-1:0] imm_i,
    output logic [W-1:0]  result_o,
    output logic          bound_err_o,
    output logic          div_err_o
);
    alu_op_e    op;
    alu_form_e  form;
    logic [W-1:0] eff_b, arith_res, quot, rem, lsh_res, ash_res;
    logic         arith_berr, zero_div;
    alu_flags_t   flags;

    assign op   = alu_op_e'(op_i);
    assign form = alu_form_e'(form_i);

    alu_opnd_ext #(.W(W), .IW(IW)) u_ext (
        .form(form), .reg_b(opb_i), .imm(imm_i), .eff_b(eff_b)
    );

    alu_arith_unit #(.W(W)) u_arith (
        .op(op), .a(opa_i), .b(eff_b), .res(arith_res), .bound_err(arith_berr)
    );

    alu_div_unit #(.W(W)) u_div (
        .a(opa_i), .b(eff_b), .quot(quot), .rem(rem), .zero_div(zero_div)
    );

    alu_shift_unit #(.W(W), .ARITH(1'b0)) u_lsh (
        .a(opa_i), .cnt(eff_b), .res(lsh_res)
    );

    alu_shift_unit #(.W(W), .ARITH(1'b1)) u_ash (
        .a(opa_i), .cnt(eff_b), .res(ash_res)
    );

    always_comb begin
        flags = '0;
        unique case (op)
            OP_DIV: begin
                result_o      = quot;
                flags.div_err = zero_div;
            end
            OP_MOD: begin
                result_o      = rem;
                flags.div_err = zero_div;
            end
            OP_LSH: result_o = lsh_res;
            OP_ASH: result_o = ash_res;
            OP_CHK: begin
                result_o        = arith_res;
                flags.bound_err = arith_berr;
            end
            default: result_o = arith_res;
        endcase
    end

    assign bound_err_o = flags.bound_err;
    assign div_err_o   = flags.div_err;

    always_comb begin
        if (div_err_o)
            AST_DIVZERO_RESULT: assert (result_o == '0) else $error("zero divisor result"); // R5
        AST_DIVZERO_FLAG: assert (div_err_o == (((op == OP_DIV) || (op == OP_MOD)) && (eff_b == '0)))
            else $error("divide flag mismatch"); // R5
        if (op == OP_CMP)
            AST_CMP_RANGE: assert ((result_o == '0) || (result_o == '1) || (result_o == {{(W-1){1'b0}}, 1'b1}))
                else $error("compare code"); // R6
        if (op == OP_BIC)
            AST_BIC_CLEARS: assert ((result_o & eff_b) == '0) else $error("bit clear"); // R8
        if ((op == OP_CHK) && opa_i[W-1])
            AST_CHK_NEGATIVE: assert (bound_err_o) else $error("negative index"); // R11
        if (op == OP_CHK)
            AST_CHK_PASS: assert (result_o == opa_i) else $error("check passthrough"); // R11
        if ((op != OP_CHK) && (op != OP_DIV) && (op != OP_MOD))
            AST_FLAGS_QUIET: assert (!bound_err_o && !div_err_o) else $error("stray flag"); // R12
        if ((op == OP_LSH) && !eff_b[W-1] && (eff_b >= W))
            AST_SHIFT_FAR: assert (result_o == '0) else $error("far left shift"); // R9
    end
endmodule

// File: tb/tb_regimm_alu.sv
module tb_regimm_alu;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 20000;
    localparam int  N_RANDOM   = 3000;

    logic        clk = 1'b0;
    logic [3:0]  op;
    logic [1:0]  form;
    logic [31:0] a, b, res;
    logic [15:0] imm;
    logic        berr, derr;
    int          n_checks = 0;
    int          n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    regimm_alu dut (
        .op_i(op), .form_i(form), .opa_i(a), .opb_i(b), .imm_i(imm),
        .result_o(res), .bound_err_o(berr), .div_err_o(derr)
    );

    function automatic logic [31:0] ref_b(input logic [1:0] f, input logic [31:0] rb, input logic [15:0] im);
        if (f == 2'd1) return {{16{im[15]}}, im};
        if (f == 2'd2) return {16'h0, im};
        return rb;
    endfunction

    function automatic logic [31:0] ref_shift(input logic [31:0] x, input logic [31:0] c, input bit arith);
        longint cnt, mag;
        cnt = longint'($signed(c));
        if (cnt >= 0) begin
            if (cnt >= 32) return 32'h0;
            return x << cnt;
        end
        mag = -cnt;
        if (mag >= 32) return (arith && x[31]) ? 32'hFFFF_FFFF : 32'h0;
        if (arith) return $unsigned($signed(x) >>> mag);
        return x >> mag;
    endfunction

    task automatic model(input logic [3:0] o, input logic [1:0] f, input logic [31:0] ra,
                         input logic [31:0] rb, input logic [15:0] im,
                         output logic [31:0] r, output logic be, output logic de);
        logic [31:0] bb;
        longint la, lb, q;
        bb = ref_b(f, rb, im);
        la = longint'($signed(ra));
        lb = longint'($signed(bb));
        r = 32'h0; be = 1'b0; de = 1'b0;
        case (o)
            4'd0: r = ra + bb;
            4'd1: r = ra - bb;
            4'd2: begin q = la * lb; r = q[31:0]; end
            4'd3: if (lb == 0) de = 1'b1; else begin q = la / lb; r = q[31:0]; end
            4'd4: if (lb == 0) de = 1'b1; else begin q = la % lb; r = q[31:0]; end
            4'd5: r = (la < lb) ? 32'hFFFF_FFFF : ((la == lb) ? 32'h0 : 32'h1);
            4'd6: r = ra | bb;
            4'd7: r = ra ^ bb;
            4'd8: r = ra & bb;
            4'd9: r = ra & ~bb;
            4'd10: r = ref_shift(ra, bb, 1'b0);
            4'd11: r = ref_shift(ra, bb, 1'b1);
            4'd12: begin r = ra; be = (la < 0) || (la >= lb); end
            default: r = 32'h0;
        endcase
    endtask

    function automatic string req_of(input logic [3:0] o);
        case (o)
            4'd0, 4'd1: return "R1";
            4'd2: return "R3";
            4'd3, 4'd4: return "R4";
            4'd5: return "R6";
            4'd6, 4'd7, 4'd8: return "R7";
            4'd9: return "R8";
            4'd10: return "R9";
            4'd11: return "R10";
            4'd12: return "R11";
            default: return "R12";
        endcase
    endfunction

    task automatic run(input string req, input logic [3:0] o, input logic [1:0] f,
                       input logic [31:0] ra, input logic [31:0] rb, input logic [15:0] im);
        logic [31:0] er;
        logic ebe, ede;
        @(posedge clk);
        op = o; form = f; a = ra; b = rb; imm = im;
        model(o, f, ra, rb, im, er, ebe, ede);
        @(negedge clk);
        n_checks++;
        if (res !== er || berr !== ebe || derr !== ede) begin
            n_fail++;
            $display("FAIL %s op=%0d form=%0d a=%h b=%h imm=%h: got res=%h berr=%b derr=%b expected res=%h berr=%b derr=%b",
                     req, o, f, ra, rb, im, res, berr, derr, er, ebe, ede);
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        op = 4'd0; form = 2'd0; a = '0; b = '0; imm = '0;
        @(negedge clk);
        n_checks++;
        if (res !== 32'h0 || berr !== 1'b0 || derr !== 1'b0) begin
            n_fail++;
            $display("FAIL R12 idle inputs: got res=%h berr=%b derr=%b expected 0 0 0", res, berr, derr);
        end
        run("R1",  4'd0, 2'd0, 32'hFFFF_FFFF, 32'h1, 16'h0);
        run("R1",  4'd1, 2'd0, 32'h0, 32'h1, 16'h0);
        run("R2",  4'd0, 2'd1, 32'h10, 32'h5555, 16'hFFFF);
        run("R2",  4'd0, 2'd2, 32'h10, 32'h5555, 16'hFFFF);
        run("R2",  4'd0, 2'd3, 32'h10, 32'h5555, 16'hFFFF);
        run("R3",  4'd2, 2'd0, 32'h8000_0001, 32'h3, 16'h0);
        run("R4",  4'd3, 2'd1, 32'hFFFF_FFF9, 32'h0, 16'h0002);
        run("R4",  4'd4, 2'd1, 32'hFFFF_FFF9, 32'h0, 16'h0002);
        run("R4",  4'd3, 2'd0, 32'h8000_0000, 32'hFFFF_FFFF, 16'h0);
        run("R4",  4'd4, 2'd0, 32'h8000_0000, 32'hFFFF_FFFF, 16'h0);
        run("R5",  4'd3, 2'd0, 32'h1234, 32'h0, 16'h0);
        run("R5",  4'd4, 2'd2, 32'h1234, 32'h7, 16'h0);
        run("R6",  4'd5, 2'd0, 32'hFFFF_FFFF, 32'h1, 16'h0);
        run("R6",  4'd5, 2'd1, 32'h5, 32'h0, 16'h0005);
        run("R6",  4'd5, 2'd2, 32'h1, 32'h0, 16'hFFFF);
        run("R7",  4'd7, 2'd2, 32'hF0F0_F0F0, 32'h0, 16'hFFFF);
        run("R8",  4'd9, 2'd1, 32'hFFFF_FFFF, 32'h0, 16'h00F0);
        run("R9",  4'd10, 2'd1, 32'h8000_0001, 32'h0, 16'hFFFF);
        run("R9",  4'd10, 2'd0, 32'hFFFF_FFFF, 32'd32, 16'h0);
        run("R9",  4'd10, 2'd0, 32'hFFFF_FFFF, 32'h8000_0000, 16'h0);
        run("R9",  4'd10, 2'd2, 32'h1, 32'h0, 16'd31);
        run("R10", 4'd11, 2'd1, 32'h8000_0000, 32'h0, 16'hFFFC);
        run("R10", 4'd11, 2'd1, 32'h8000_0000, 32'h0, 16'hFFE0);
        run("R10", 4'd11, 2'd1, 32'h4000_0000, 32'h0, 16'hFFC0);
        run("R10", 4'd11, 2'd2, 32'h3, 32'h0, 16'd4);
        run("R11", 4'd12, 2'd2, 32'd9, 32'h0, 16'd10);
        run("R11", 4'd12, 2'd2, 32'd10, 32'h0, 16'd10);
        run("R11", 4'd12, 2'd0, 32'hFFFF_FFFF, 32'd100, 16'h0);
        run("R12", 4'd14, 2'd0, 32'h1234, 32'h0, 16'h0);
        for (int i = 0; i < N_RANDOM; i++) begin
            logic [3:0]  ro;
            logic [1:0]  rf;
            logic [31:0] ra, rb;
            logic [15:0] ri;
            ro = 4'($urandom_range(0, 15));
            rf = 2'($urandom_range(0, 3));
            ra = $urandom();
            case ($urandom_range(0, 3))
                0: rb = 32'h0;
                1: rb = 32'($signed(6'($urandom_range(0, 63))));
                default: rb = $urandom();
            endcase
            ri = ($urandom_range(0, 5) == 0) ? 16'h0 : 16'($urandom());
            run(req_of(ro), ro, rf, ra, rb, ri);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule